// File: doc/BRIEF.md
# Microsequencer Next-Address Unit

This block holds the microprogram counter of a paged control store and chooses the address of the next microinstruction every clock. The control store has 4096 words, arranged as 16 pages of 256 words. So an address is a 4-bit page number above an 8-bit word offset. Each cycle the block takes the fields of the instruction that is executing: a 3-bit jump-control code, an 8-bit jump-address field, the branch condition already chosen by the condition logic, the low nibble of a dispatch register, the current task number, the next opcode byte, and a flag that reports the opcode-byte buffer is empty. It then updates the counter.

Ordinary branches stay on the current page. An instruction can also load a one-shot page override, which applies only to the branch in the instruction that follows. Subroutine linkage uses one return register per task. A call writes the return register of the running task, and a return reads it back. One form of return jumps into a vector of opcode entry points, spaced four words apart. An empty opcode buffer overrides every other action and sends control to address zero.

Top module: `useq_next_addr`

## Requirements
- R1: While reset is active, `upc` is 0. The reset is released in step with the clock. After release, a goto with field 0 keeps `upc` at 0.
- R2: Jump-control code 0 (goto) sets `upc` to {current page, `ja`}. Codes 5, 6 and 7 behave the same way as code 0.
- R3: When `ld_page` is high, the next branch uses `ld_page_num` as its page instead of the current page. The override is used by one instruction only and is then dropped.
- R4: Code 4 (conditional goto) sets `upc` to {page, `ja[7:1]`, t}, where t = `cond` XOR `ja[0]`. A true outcome therefore lands on the odd word of the pair and a false outcome on the even word.
- R5: Code 2 (dispatch) sets `upc` to {page, `ja[7:4]`, `disp_lo`}.
- R6: Code 1 (call) branches the same way as a goto. It also writes the return register of task `task_id` with {current page, 4'b0000, (current word + 1) mod 16}.
- R7: Code 3 with `ja[7]`=0 sets `upc` to the return register of task `task_id`.
- R8: Code 3 with `ja[7]`=1 sets `upc` to 1025 + 4×`opbyte`.
- R9: There are 16 return registers, one per task. A call by one task leaves the return registers of the other tasks unchanged.
- R10: When `buf_empty` is high, `upc` becomes 0 whatever the code is. If the code is 1, the return register of the task is loaded with the current address itself. For any other code, the return register is not written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| task_id | input | 4 | Number of the running task; selects its return register |
| jc | input | 3 | Jump-control code |
| ja | input | 8 | Jump-address field |
| cond | input | 1 | Selected branch condition |
| disp_lo | input | 4 | Low nibble of the dispatch register |
| ld_page | input | 1 | Load a one-shot page override for the next instruction |
| ld_page_num | input | 4 | Page value for the override |
| opbyte | input | 8 | Next opcode byte |
| buf_empty | input | 1 | Opcode buffer empty; forces a trap |
| upc | output | 12 | Current microinstruction address |

## Verification
The counter is registered. A wrong target, a pair bit with the wrong polarity or a lost page override therefore shows on `upc` one cycle after the instruction that caused it. The return registers cannot be seen directly, so a link word that is corrupted or written to the wrong task stays hidden until a later return by that task. The bench always follows a call with returns, both for the calling task and for other tasks. A page override that is not dropped after one use shows up on the second branch after the load, and the bench checks that branch.

// File: rtl/useq_pkg.sv
package useq_pkg;

  typedef enum logic [2:0] {
    JC_GOTO = 3'd0,
    JC_CALL = 3'd1,
    JC_DISP = 3'd2,
    JC_RET  = 3'd3,
    JC_COND = 3'd4
  } jc_e;

endpackage

// File: rtl/useq_page_latch.sv
module useq_page_latch #(
  parameter int PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rst_int_n,
  input  logic              ld,
  input  logic [PAGE_W-1:0] ld_num,
  input  logic [PAGE_W-1:0] cur_page,
  output logic [PAGE_W-1:0] page_sel
);

  logic              pend_vld_q, pend_vld_d;
  logic [PAGE_W-1:0] pend_pg_q, pend_pg_d;

  always_comb begin
    pend_vld_d = ld;
    pend_pg_d  = pend_pg_q;
    if (ld) pend_pg_d = ld_num;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      pend_vld_q <= 1'b0;
      pend_pg_q  <= '0;
    end else begin
      pend_vld_q <= pend_vld_d;
      if (ld) pend_pg_q <= pend_pg_d;
    end
  end

  assign page_sel = pend_vld_q ? pend_pg_q : cur_page;

  // R3: the page loaded in one cycle steers the branch of the next
  a_r3_page_override: assert property (@(posedge clk) disable iff (!rst_int_n)
    ld |=> (page_sel == $past(ld_num)));

  // R3: without a load, the branch page is the current page
  a_r3_page_one_shot: assert property (@(posedge clk) disable iff (!rst_int_n)
    !ld |=> (page_sel == cur_page));

endmodule

// File: rtl/useq_link_file.sv
module useq_link_file #(
  parameter int ADDR_W = 12,
  parameter int TASKS  = 16,
  localparam int TASK_W = $clog2(TASKS)
) (
  input  logic              clk,
  input  logic              rst_int_n,
  input  logic [TASK_W-1:0] idx,
  input  logic              we,
  input  logic [ADDR_W-1:0] wdata,
  output logic [ADDR_W-1:0] rdata
);

  logic [ADDR_W-1:0] link_mem [TASKS];

  always_ff @(posedge clk) begin
    if (we) link_mem[idx] <= wdata;
  end

  assign rdata = link_mem[idx];

  // R6 / R9: a write lands in the slot of the writing task
  a_r6_link_written: assert property (@(posedge clk) disable iff (!rst_int_n)
    we |=> (link_mem[$past(idx)] == $past(wdata)));

endmodule

// File: rtl/useq_target_mux.sv
module useq_target_mux
  import useq_pkg::*;
#(
  parameter int PAGE_W    = 4,
  parameter int WORD_W    = 8,
  parameter int DISP_W    = 4,
  parameter int OPC_W     = 8,
  parameter int OPC_BASE  = 1025,
  parameter int OPC_SHIFT = 2,
  localparam int ADDR_W   = PAGE_W + WORD_W
) (
  input  logic [ADDR_W-1:0] cur,
  input  logic [2:0]        jc,
  input  logic [WORD_W-1:0] ja,
  input  logic              cond,
  input  logic [DISP_W-1:0] disp_lo,
  input  logic [PAGE_W-1:0] page_sel,
  input  logic [ADDR_W-1:0] ret_addr,
  input  logic [OPC_W-1:0]  opbyte,
  input  logic              trap,
  output logic [ADDR_W-1:0] nxt,
  output logic              link_we,
  output logic [ADDR_W-1:0] link_data
);

  jc_e               code;
  logic [DISP_W-1:0] lo_inc;
  logic [ADDR_W-1:0] opc_vec;
  logic              taken;

  always_comb begin
    code    = jc_e'(jc);
    lo_inc  = cur[DISP_W-1:0] + DISP_W'(1);
    opc_vec = ADDR_W'(OPC_BASE) + (ADDR_W'(opbyte) << OPC_SHIFT);
    taken   = cond ^ ja[0];

    unique case (code)
      JC_DISP: nxt = {page_sel, ja[WORD_W-1:DISP_W], disp_lo};
      JC_RET:  nxt = ja[WORD_W-1] ? opc_vec : ret_addr;
      JC_COND: nxt = {page_sel, ja[WORD_W-1:1], taken};
      default: nxt = {page_sel, ja};
    endcase
    if (trap) nxt = '0;

    link_we = (code == JC_CALL);
    if (trap) link_data = cur;
    else      link_data = {cur[ADDR_W-1:WORD_W], {(WORD_W-DISP_W){1'b0}}, lo_inc};
  end

endmodule

// File: rtl/useq_next_addr.sv
module useq_next_addr
  import useq_pkg::*;
#(
  parameter int PAGE_W    = 4,
  parameter int WORD_W    = 8,
  parameter int TASKS     = 16,
  parameter int DISP_W    = 4,
  parameter int OPC_W     = 8,
  parameter int OPC_BASE  = 1025,
  parameter int OPC_SHIFT = 2,
  parameter int SYNC_LEN  = 2,
  localparam int ADDR_W   = PAGE_W + WORD_W,
  localparam int TASK_W   = $clog2(TASKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TASK_W-1:0] task_id,
  input  logic [2:0]        jc,
  input  logic [WORD_W-1:0] ja,
  input  logic              cond,
  input  logic [DISP_W-1:0] disp_lo,
  input  logic              ld_page,
  input  logic [PAGE_W-1:0] ld_page_num,
  input  logic [OPC_W-1:0]  opbyte,
  input  logic              buf_empty,
  output logic [ADDR_W-1:0] upc
);

  logic [SYNC_LEN-1:0] rst_sync_q;
  logic                rst_int_n;
  logic [ADDR_W-1:0]   pc_q, pc_d;
  logic [PAGE_W-1:0]   page_sel;
  logic [ADDR_W-1:0]   ret_addr;
  logic                link_we;
  logic [ADDR_W-1:0]   link_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_LEN-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[SYNC_LEN-1];

  useq_page_latch #(.PAGE_W(PAGE_W)) u_page (
    .clk       (clk),
    .rst_int_n (rst_int_n),
    .ld        (ld_page),
    .ld_num    (ld_page_num),
    .cur_page  (pc_q[ADDR_W-1:WORD_W]),
    .page_sel  (page_sel)
  );

  useq_link_file #(.ADDR_W(ADDR_W), .TASKS(TASKS)) u_link (
    .clk       (clk),
    .rst_int_n (rst_int_n),
    .idx       (task_id),
    .we        (link_we),
    .wdata     (link_data),
    .rdata     (ret_addr)
  );

  useq_target_mux #(
    .PAGE_W(PAGE_W), .WORD_W(WORD_W), .DISP_W(DISP_W), .OPC_W(OPC_W),
    .OPC_BASE(OPC_BASE), .OPC_SHIFT(OPC_SHIFT)
  ) u_mux (
    .cur       (pc_q),
    .jc        (jc),
    .ja        (ja),
    .cond      (cond),
    .disp_lo   (disp_lo),
    .page_sel  (page_sel),
    .ret_addr  (ret_addr),
    .opbyte    (opbyte),
    .trap      (buf_empty),
    .nxt       (pc_d),
    .link_we   (link_we),
    .link_data (link_data)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) pc_q <= '0;
    else            pc_q <= pc_d;
  end

  assign upc = pc_q;

  // R10: an empty opcode buffer lands at address zero
  a_r10_trap_zero: assert property (@(posedge clk) disable iff (!rst_int_n)
    buf_empty |=> (upc == '0));

  // R5: dispatch low nibble follows the dispatch register
  a_r5_disp_low: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!buf_empty && jc == JC_DISP) |=> (upc[DISP_W-1:0] == $past(disp_lo)));

  // R4: pair bit follows the modified condition
  a_r4_pair_select: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!buf_empty && jc == JC_COND) |=> (upc[0] == $past(cond ^ ja[0])));

  // R8: opcode-stream return reaches the entry vector
  a_r8_opcode_vector: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!buf_empty && jc == JC_RET && ja[WORD_W-1])
      |=> (upc == ADDR_W'(OPC_BASE) + (ADDR_W'($past(opbyte)) << OPC_SHIFT)));

  // R2: a plain goto keeps the word field as given
  a_r2_goto_word: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!buf_empty && jc == JC_GOTO) |=> (upc[WORD_W-1:0] == $past(ja)));

endmodule

// File: tb/tb_useq_next_addr.sv
module tb_useq_next_addr;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  task_id;
  logic [2:0]  jc;
  logic [7:0]  ja;
  logic        cond;
  logic [3:0]  disp_lo;
  logic        ld_page;
  logic [3:0]  ld_page_num;
  logic [7:0]  opbyte;
  logic        buf_empty;
  logic [11:0] upc;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  useq_next_addr dut (
    .clk(clk), .rst_n(rst_n), .task_id(task_id), .jc(jc), .ja(ja),
    .cond(cond), .disp_lo(disp_lo), .ld_page(ld_page),
    .ld_page_num(ld_page_num), .opbyte(opbyte), .buf_empty(buf_empty),
    .upc(upc)
  );

  task automatic chk(input string req, input logic [11:0] got, input logic [11:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: upc=%03h expected %03h", req, got, exp);
    end
  endtask

  task automatic op(input logic [2:0] c, input logic [7:0] a);
    jc = c;
    ja = a;
    @(posedge clk);
    @(negedge clk);
    ld_page   = 1'b0;
    buf_empty = 1'b0;
  endtask

  task automatic jump_to(input logic [11:0] addr);
    ld_page     = 1'b1;
    ld_page_num = addr[11:8];
    op(3'd0, 8'h00);
    op(3'd0, addr[7:0]);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; task_id = 0; jc = 3'd0; ja = 8'h00; cond = 0; disp_lo = 0;
    ld_page = 0; ld_page_num = 0; opbyte = 0; buf_empty = 0;
    repeat (3) @(negedge clk);
    chk("R1 during reset", upc, 12'h000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 after release", upc, 12'h000);
  endtask

  task automatic t_goto();
    jump_to(12'h3A5);
    chk("R2 setup", upc, 12'h3A5);
    op(3'd0, 8'h12);
    chk("R2 goto stays on page", upc, 12'h312);
    op(3'd6, 8'hC3);
    chk("R2 reserved code as goto", upc, 12'h3C3);
  endtask

  task automatic t_page();
    ld_page = 1'b1; ld_page_num = 4'h7;
    op(3'd0, 8'h40);
    chk("R3 load not yet active", upc, 12'h340);
    op(3'd0, 8'h55);
    chk("R3 override used", upc, 12'h755);
    ld_page_num = 4'hE;
    op(3'd0, 8'h01);
    chk("R3 override dropped", upc, 12'h701);
  endtask

  task automatic t_cond();
    jump_to(12'h500);
    cond = 1; op(3'd4, 8'h20);
    chk("R4 true to odd", upc, 12'h521);
    cond = 0; op(3'd4, 8'h20);
    chk("R4 false to even", upc, 12'h520);
    cond = 1; op(3'd4, 8'h21);
    chk("R4 modifier inverts true", upc, 12'h520);
    cond = 0; op(3'd4, 8'h21);
    chk("R4 modifier inverts false", upc, 12'h521);
  endtask

  task automatic t_disp();
    jump_to(12'h200);
    disp_lo = 4'h9;
    op(3'd2, 8'hB7);
    chk("R5 dispatch", upc, 12'h2B9);
    ld_page = 1'b1; ld_page_num = 4'hC; disp_lo = 4'h0;
    op(3'd0, 8'h00);
    op(3'd2, 8'h3F);
    chk("R5 dispatch with page override", upc, 12'hC30);
  endtask

  task automatic t_call_ret();
    task_id = 4'd1;
    jump_to(12'h4AF);
    op(3'd1, 8'h30);
    chk("R6 call target", upc, 12'h430);
    op(3'd3, 8'h00);
    chk("R7 return wraps low nibble", upc, 12'h400);
    jump_to(12'h4A3);
    op(3'd1, 8'h77);
    op(3'd3, 8'h7F);
    chk("R7 return after call", upc, 12'h404);
  endtask

  task automatic t_opcode();
    opbyte = 8'h00;
    op(3'd3, 8'h80);
    chk("R8 opcode vector 0", upc, 12'h401);
    opbyte = 8'hFF;
    op(3'd3, 8'hFF);
    chk("R8 opcode vector 255", upc, 12'h7FD);
  endtask

  task automatic t_tasks();
    task_id = 4'd2;
    jump_to(12'h110);
    op(3'd1, 8'h00);
    task_id = 4'd5;
    jump_to(12'h6E7);
    op(3'd1, 8'h00);
    task_id = 4'd2;
    op(3'd3, 8'h00);
    chk("R9 task 2 link kept", upc, 12'h101);
    task_id = 4'd5;
    op(3'd3, 8'h00);
    chk("R9 task 5 link", upc, 12'h608);
  endtask

  task automatic t_trap();
    task_id = 4'd6;
    jump_to(12'h2C4);
    buf_empty = 1'b1;
    op(3'd1, 8'h33);
    chk("R10 trap on call", upc, 12'h000);
    op(3'd3, 8'h00);
    chk("R10 call trap saves current", upc, 12'h2C4);
    task_id = 4'd7;
    jump_to(12'h315);
    op(3'd1, 8'h40);
    buf_empty = 1'b1;
    op(3'd0, 8'h99);
    chk("R10 trap on goto", upc, 12'h000);
    op(3'd3, 8'h00);
    chk("R10 goto trap leaves link", upc, 12'h306);
    buf_empty = 1'b1; opbyte = 8'h10;
    op(3'd3, 8'h80);
    chk("R10 trap beats opcode return", upc, 12'h000);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_goto();
    t_page();
    t_cond();
    t_disp();
    t_call_ret();
    t_opcode();
    t_tasks();
    t_trap();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule